// File: doc/BRIEF.md
# MDIO Management Master

This block is a clause 22 MDIO management master placed beside an Ethernet MAC. Software controls it through six 32-bit registers on a single-cycle register port. It loads a PHY and register address, then either writes a 16-bit value or sets a read command bit. The block serialises the frame on MDIO with a clock it derives from the system clock, and software polls an indicator register until the frame is done. After a read, the returned 16-bit value is available in a status register.

Each frame has 64 MDC periods: a preamble of 32 ones, the start pattern 01, an opcode (01 for write, 10 for read), a 5-bit PHY address, a 5-bit register address, a 2-bit turnaround and 16 data bits. Every field goes out most significant bit first. On a read, the block releases MDIO from the turnaround onwards and takes in the PHY's data bits on rising MDC edges.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, MDC is low and MDIO is not driven. The configuration register reads 0x00000007. The command, address, write-data, status and indicator registers all read zero.
- R2: The address register (offset 0x28) keeps the PHY address in bits 12:8 and the register number in bits 4:0. It reads back only those fields.
- R3: A write to offset 0x2C while idle starts a write frame carrying bits 15:0 of the written value. MDIO drives for the whole frame: 32 ones, then 01, 01, the PHY address, the register address, 10 and the data, most significant bit first.
- R4: A write to the command register (offset 0x24) starts a read frame only when it changes bit 0 from 0 to 1 while idle. A read frame drives the same header as R3 with opcode 10, and it releases MDIO (output enable low) from the first turnaround bit to the end of the frame.
- R5: Each MDC low phase and each high phase lasts D+1 system clocks, where D is configuration bits 3:0. The value of D is taken when the frame starts. MDC starts low in the cycle after the start. Indicator bit 0 (busy) reads 1 from that cycle until the final falling edge, 128*(D+1) cycles later. MDC stays low while idle.
- R6: MDIO output changes only when MDC falls. MDIO holds its value for the whole MDC high phase.
- R7: A read samples MDIO on the rising MDC edges of the 16 data bits, first bit into bit 15. When the frame ends, the status register (offset 0x30) bits 15:0 hold the sampled word.
- R8: Indicator bit 2 (invalid) is set when a read starts and cleared when that read ends. Write frames leave it unchanged.
- R9: A start request (a write to 0x2C, or a 0-to-1 change of command bit 0) that arrives while busy is ignored. The running frame goes on unchanged.
- R10: Writing configuration bit 31 as 1 aborts any frame at once: busy and invalid clear, MDC goes low and MDIO is released. While bit 31 stays 1, start requests are ignored. Writing bit 31 as 0 re-enables starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for a write access |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench drives write frames and read frames with different addresses, data words and divider settings, including the fastest divider, where each MDC phase is one clock. These runs check that frame framing, edge timing and the release point do not depend on the divider. Each read uses a different response word, so a bit-order or off-by-one sampling fault shows in the status value. Further runs try a repeated command bit, start requests during a frame, a divider change during a frame and a management reset during a frame. Each of these must leave the clock-by-clock MDC, MDIO and busy pattern from the reference model unchanged, or cut it short exactly where the model does.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int DIV_W     = 4,
  parameter int DIV_RESET = 7,
  parameter int PRE_LEN   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] TA_IDX  = IDX_W'(PRE_LEN + 14);
  localparam logic [IDX_W-1:0] DAT_IDX = IDX_W'(PRE_LEN + 16);
  localparam logic [IDX_W-1:0] END_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [ADDR_W-1:0] OFF_CFG = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] OFF_CMD = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] OFF_ADR = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] OFF_WDT = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] OFF_STS = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] OFF_IND = ADDR_W'(8'h34);

  logic                 cfg_rst, cmd_rd, busy, is_read, invalid, mdc_q;
  logic [DIV_W-1:0]     cfg_div, half_lim, div_cnt;
  logic [4:0]           phy_a, reg_a;
  logic [15:0]          wr_data, rd_data, rd_shift;
  logic [IDX_W-1:0]     bit_idx;
  logic [FRAME_LEN-1:0] sreg;
  logic                 unused_bits;

  wire wr        = bus_en && bus_we;
  wire hit_cfg   = wr && bus_addr == OFF_CFG;
  wire hit_cmd   = wr && bus_addr == OFF_CMD;
  wire hit_adr   = wr && bus_addr == OFF_ADR;
  wire hit_wdt   = wr && bus_addr == OFF_WDT;
  wire can_start = !busy && !cfg_rst;
  wire start_wr  = hit_wdt && can_start;
  wire start_rd  = hit_cmd && bus_wdata[0] && !cmd_rd && can_start;
  wire phase_end = div_cnt == half_lim;

  assign unused_bits = ^bus_wdata[30:16];
  assign mdc     = mdc_q;
  assign mdio_o  = sreg[FRAME_LEN-1];
  assign mdio_oe = busy && !(is_read && bit_idx >= TA_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rst <= 1'b0;
      cfg_div <= DIV_W'(DIV_RESET);
      cmd_rd  <= 1'b0;
      phy_a   <= '0;
      reg_a   <= '0;
      wr_data <= '0;
    end else begin
      if (hit_cfg) begin
        cfg_rst <= bus_wdata[31];
        cfg_div <= bus_wdata[DIV_W-1:0];
      end
      if (hit_cmd) cmd_rd <= bus_wdata[0];
      if (hit_adr) begin
        phy_a <= bus_wdata[12:8];
        reg_a <= bus_wdata[4:0];
      end
      if (hit_wdt) wr_data <= bus_wdata[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      is_read  <= 1'b0;
      invalid  <= 1'b0;
      mdc_q    <= 1'b0;
      half_lim <= '0;
      div_cnt  <= '0;
      bit_idx  <= '0;
      sreg     <= '0;
      rd_shift <= '0;
      rd_data  <= '0;
    end else if (hit_cfg && bus_wdata[31]) begin
      busy    <= 1'b0;
      invalid <= 1'b0;
      mdc_q   <= 1'b0;
      div_cnt <= '0;
      bit_idx <= '0;
      sreg    <= '0;
    end else if (start_wr || start_rd) begin
      busy     <= 1'b1;
      is_read  <= start_rd;
      invalid  <= start_rd;
      mdc_q    <= 1'b0;
      div_cnt  <= '0;
      bit_idx  <= '0;
      half_lim <= cfg_div;
      sreg     <= start_rd ? {{PRE_LEN{1'b1}}, 4'b0110, phy_a, reg_a, 2'b11, 16'hFFFF}
                           : {{PRE_LEN{1'b1}}, 4'b0101, phy_a, reg_a, 2'b10, bus_wdata[15:0]};
    end else if (busy) begin
      if (!phase_end) begin
        div_cnt <= div_cnt + 1'b1;
      end else begin
        div_cnt <= '0;
        mdc_q   <= !mdc_q;
        if (!mdc_q) begin
          if (is_read && bit_idx >= DAT_IDX) rd_shift <= {rd_shift[14:0], mdio_i};
        end else if (bit_idx == END_IDX) begin
          busy <= 1'b0;
          sreg <= '0;
          if (is_read) begin
            rd_data <= rd_shift;
            invalid <= 1'b0;
          end
        end else begin
          bit_idx <= bit_idx + 1'b1;
          sreg    <= {sreg[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_CFG: begin
        bus_rdata[31]        = cfg_rst;
        bus_rdata[DIV_W-1:0] = cfg_div;
      end
      OFF_CMD: bus_rdata[0]     = cmd_rd;
      OFF_ADR: bus_rdata[12:0]  = {phy_a, 3'b000, reg_a};
      OFF_WDT: bus_rdata[15:0]  = wr_data;
      OFF_STS: bus_rdata[15:0]  = rd_data;
      OFF_IND: begin
        bus_rdata[0] = busy;
        bus_rdata[2] = invalid;
      end
      default: bus_rdata = '0;
    endcase
  end

  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdc_q); // R5
  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> div_cnt <= half_lim); // R5
  AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) busy && $past(busy) && mdc_q |-> $stable(mdio_o)); // R6
  AST_INVALID_IN_READ: assert property (@(posedge clk) disable iff (!rst_n) invalid |-> busy && is_read); // R8
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) busy && $past(busy) |-> $stable(half_lim) && $stable(is_read)); // R9
  AST_RESET_ABORT: assert property (@(posedge clk) disable iff (!rst_n) hit_cfg && bus_wdata[31] |=> !busy && !mdc_q && !mdio_oe); // R10
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h34;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int checks = 0, errors = 0, cycles = 0;

  mdio_mgmt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  int act = 0, t = 0, h = 8;
  logic m_rst = 0, m_cmd = 0, m_inv = 0, m_read = 0;
  logic [3:0] m_div = 4'd7;
  logic [4:0] m_phy = 0, m_reg = 0;
  logic [15:0] m_stat = 0, resp = 16'h0000;
  logic [63:0] frame = '0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at t=%0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      act = 0; t = 0; h = 8; m_rst = 0; m_div = 4'd7; m_cmd = 0;
      m_inv = 0; m_stat = 0; m_phy = 0; m_reg = 0; m_read = 0;
    end else begin
      int started;
      started = 0;
      if (bus_en && bus_we) begin
        case (bus_addr)
          8'h20: begin
            m_rst = bus_wdata[31];
            m_div = bus_wdata[3:0];
            if (bus_wdata[31]) begin act = 0; m_inv = 0; end
          end
          8'h24: begin
            if (bus_wdata[0] && !m_cmd && act == 0 && !m_rst) begin
              started = 1; m_read = 1;
              frame = {32'hFFFF_FFFF, 4'b0110, m_phy, m_reg, 2'b11, 16'hFFFF};
            end
            m_cmd = bus_wdata[0];
          end
          8'h28: begin m_phy = bus_wdata[12:8]; m_reg = bus_wdata[4:0]; end
          8'h2C: if (act == 0 && !m_rst) begin
            started = 1; m_read = 0;
            frame = {32'hFFFF_FFFF, 4'b0101, m_phy, m_reg, 2'b10, bus_wdata[15:0]};
          end
          default: ;
        endcase
      end
      if (started != 0) begin
        act = 1; t = 0; h = int'(m_div) + 1;
        if (m_read) m_inv = 1;
      end else if (act != 0) begin
        t++;
        if (t == 128 * h) begin
          act = 0;
          if (m_read) begin m_stat = resp; m_inv = 0; end
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int idx;
      logic e_mdc, e_oe;
      idx = t / (2 * h);
      e_mdc = (act != 0) && ((t / h) % 2 == 1);
      e_oe = (act != 0) && !(m_read && idx >= 46);
      check("R5 mdc", {31'b0, mdc}, {31'b0, e_mdc});
      check("R4 mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
      if (e_oe) check("R3/R6 mdio_o", {31'b0, mdio_o}, {31'b0, frame[63-idx]});
      if (bus_addr == 8'h34) begin
        check("R5 busy", {31'b0, bus_rdata[0]}, {31'b0, act != 0});
        check("R8 invalid", {31'b0, bus_rdata[2]}, {31'b0, m_inv});
      end
      mdio_i = (act != 0 && m_read && idx >= 48) ? resp[15-(idx-48)] : 1'b1;
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_en = 0; bus_we = 0; bus_addr = 8'h34; bus_wdata = '0;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(posedge clk); #1;
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
    bus_addr = 8'h34;
  endtask

  task automatic wait_idle();
    while (act != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    rd_check("R1 cfg", 8'h20, 32'h7);
    rd_check("R1 cmd", 8'h24, 0);
    rd_check("R1 addr", 8'h28, 0);
    rd_check("R1 wdata", 8'h2C, 0);
    rd_check("R1 status", 8'h30, 0);
    rd_check("R1 ind", 8'h34, 0);
    check("R1 mdc/oe", {30'b0, mdc, mdio_oe}, 0);
    // R2 address layout
    bus_write(8'h28, 32'hFFFF_E51A);
    rd_check("R2 addr", 8'h28, 32'h0000_051A);
    // R3 write frame, default divider
    bus_write(8'h2C, 32'h1234_A5C3);
    wait_idle();
    rd_check("R8 invalid after write", 8'h34, 0);
    // R5 fast divider, new address
    bus_write(8'h20, 32'h1);
    bus_write(8'h28, 32'h0000_1F00);
    bus_write(8'h2C, 32'h0000_0001);
    wait_idle();
    // R4/R7 read frame
    resp = 16'hBEEF;
    bus_write(8'h28, 32'h0000_0302);
    bus_write(8'h24, 0);
    bus_write(8'h24, 1);
    wait_idle();
    rd_check("R7 status", 8'h30, 32'h0000_BEEF);
    rd_check("R8 ind", 8'h34, 0);
    // R4 repeated 1 does not start
    bus_write(8'h24, 1);
    repeat (6) @(posedge clk);
    rd_check("R4 no restart", 8'h34, 0);
    check("R4 mdc idle", {31'b0, mdc}, 0);
    // R9 starts while busy are ignored
    bus_write(8'h24, 0);
    bus_write(8'h20, 32'h2);
    bus_write(8'h2C, 32'h0000_5A5A);
    repeat (20) @(posedge clk);
    bus_write(8'h2C, 32'h0000_FFFF);
    bus_write(8'h24, 1);
    wait_idle();
    rd_check("R9 ind", 8'h34, 0);
    rd_check("R9 status kept", 8'h30, 32'h0000_BEEF);
    bus_write(8'h24, 0);
    // R10 divider sampled at start, then abort and hold
    bus_write(8'h20, 32'h3);
    bus_write(8'h2C, 32'h0000_0F0F);
    repeat (40) @(posedge clk);
    bus_write(8'h20, 32'h0);
    repeat (100) @(posedge clk);
    bus_write(8'h20, 32'h8000_0000);
    rd_check("R10 ind", 8'h34, 0);
    check("R10 released", {30'b0, mdc, mdio_oe}, 0);
    bus_write(8'h2C, 32'h0000_1111);
    bus_write(8'h24, 1);
    repeat (5) @(posedge clk);
    rd_check("R10 held", 8'h34, 0);
    bus_write(8'h24, 0);
    bus_write(8'h20, 32'h0);
    // R7 read at fastest divider, different pattern
    resp = 16'h1234;
    bus_write(8'h28, 32'h0000_1A15);
    bus_write(8'h24, 1);
    wait_idle();
    rd_check("R7 status fast", 8'h30, 32'h0000_1234);
    rd_check("R10 cfg readback", 8'h20, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule